// File: doc/BRIEF.md
# Run-Time Loop Strip Sequencer

This block cuts a loop whose trip count `n` is known only at run time into strips that each fit the vector register length. The maximum strip length depends on the element width selected for the loop. A narrower element fits more elements into the same register, so the maximum length doubles each time the element width halves. The block issues the short odd-sized strip first and full-length strips after it. For every strip it reports the length to load into the length register and the index of the first element.

A single-cycle `start` pulse loads `n` and a width code. Strips then leave one at a time over a valid/ready handshake. Each strip carries its length, its start index and a flag that marks the final strip. After the final strip is accepted, `done` pulses for one cycle. A zero trip count issues no strips and only pulses `done`. Whatever consumes the strips and runs them lies outside this block.

Top module: `strip_seq`

## Requirements
- R1: The width code selects the maximum strip length MVL as 64 << code: code 0 gives 64 (64-bit elements), code 1 gives 128 (32-bit), code 2 gives 256 (16-bit) and code 3 gives 512 (8-bit).
- R2: On a start accepted while idle with n > 0, `strip_valid` is high in the next cycle. That first strip has start index 0. Its length is n mod MVL when that value is nonzero.
- R3: Every strip after the first has length MVL.
- R4: After each accepted strip, the next start index equals the previous start index plus the previous length.
- R5: A presented strip length is never zero and never exceeds the MVL of the running sequence.
- R6: When n mod MVL is zero, no empty strip is issued and the first strip has length MVL. The total number of strips is ceil(n / MVL).
- R7: A start with n = 0 issues no strip. `done` is high for exactly one cycle, in the cycle after the start.
- R8: `strip_last` is high exactly on the strip whose start index plus length equals n. When that strip is accepted, `strip_valid` falls and `done` is high for exactly the next cycle.
- R9: While `strip_valid` is high and `strip_ready` is low, length, start index and last flag hold their values.
- R10: A start that arrives while `strip_valid` is high is ignored, including in the cycle in which the final strip is accepted. The running sequence continues unchanged and no new strip follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a sequence |
| n | input | N_W | Loop trip count, sampled with `start` |
| width_code | input | CODE_W | Element-width code, sampled with `start` |
| strip_valid | output | 1 | A strip is presented |
| strip_ready | input | 1 | The consumer accepts the presented strip |
| strip_len | output | LEN_W | Length of the presented strip |
| strip_base | output | N_W | Index of the first element of the strip |
| strip_last | output | 1 | The presented strip is the final one |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A new start request and the acceptance of the final strip can fall in the same cycle. In that cycle the sequencer is still busy, so the request has to be dropped rather than quietly begin a second sequence. The bench raises `start` with a fresh trip count on the same negative edge where it raises `strip_ready` for the last strip. It then expects `done` for one cycle and `strip_valid` low in that cycle and the next. A second directed case pulses `start` in the middle of a stalled sequence and expects the remaining strips to match the original trip count.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  // Element-width codes; MVL = base << code
  localparam logic [1:0] EW_64 = 2'd0;
  localparam logic [1:0] EW_32 = 2'd1;
  localparam logic [1:0] EW_16 = 2'd2;
  localparam logic [1:0] EW_8  = 2'd3;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ISSUE = 1'b1} seq_state_e;
endpackage

// File: rtl/strip_mvl_decode.sv
module strip_mvl_decode #(
  parameter int LOG_BASE_MVL = 6,
  parameter int CODE_W       = 2,
  parameter int LEN_W        = LOG_BASE_MVL + (1 << CODE_W)
) (
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  mvl
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  // Power-of-two MVL: halving element width doubles the element count
  always_comb begin
    mvl = ONE << (LOG_BASE_MVL + int'(code));
  end
endmodule

// File: rtl/strip_first_len.sv
module strip_first_len #(
  parameter int N_W   = 16,
  parameter int LEN_W = 10
) (
  input  logic [N_W-1:0]   n,
  input  logic [LEN_W-1:0] mvl,
  output logic [LEN_W-1:0] first_len,
  output logic             first_last
);
  logic [LEN_W-1:0] rem;

  // MVL is a power of two, so the remainder is a mask of the low bits
  always_comb begin
    rem        = LEN_W'(n) & (mvl - LEN_W'(1));
    first_len  = (rem == '0) ? mvl : rem;
    first_last = (N_W'(first_len) == n);
  end
endmodule

// File: rtl/strip_advance.sv
module strip_advance #(
  parameter int N_W   = 16,
  parameter int LEN_W = 10
) (
  input  logic [N_W-1:0]   base,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] mvl,
  input  logic [N_W-1:0]   n,
  output logic [N_W-1:0]   next_base,
  output logic             next_last
);
  logic [N_W:0] look_end;

  // Lookahead: the strip after this one always has length MVL
  always_comb begin
    next_base = base + N_W'(len);
    look_end  = {1'b0, base} + (N_W+1)'(len) + (N_W+1)'(mvl);
    next_last = (look_end == {1'b0, n});
  end
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int N_W          = 16,
  parameter int LOG_BASE_MVL = 6,
  parameter int CODE_W       = 2,
  parameter int LEN_W        = LOG_BASE_MVL + (1 << CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_W-1:0]    n,
  input  logic [CODE_W-1:0] width_code,
  output logic              strip_valid,
  input  logic              strip_ready,
  output logic [LEN_W-1:0]  strip_len,
  output logic [N_W-1:0]    strip_base,
  output logic              strip_last,
  output logic              done
);
  import strip_seq_pkg::*;

  seq_state_e       state_q;
  logic [N_W-1:0]   n_q;
  logic [LEN_W-1:0] mvl_q;
  logic [LEN_W-1:0] len_q;
  logic [N_W-1:0]   base_q;
  logic             last_q;
  logic             done_q;

  logic [LEN_W-1:0] mvl_new;
  logic [LEN_W-1:0] first_len;
  logic             first_last;
  logic [N_W-1:0]   next_base;
  logic             next_last;

  strip_mvl_decode #(
    .LOG_BASE_MVL(LOG_BASE_MVL), .CODE_W(CODE_W), .LEN_W(LEN_W)
  ) u_mvl (
    .code(width_code),
    .mvl (mvl_new)
  );

  strip_first_len #(.N_W(N_W), .LEN_W(LEN_W)) u_first (
    .n         (n),
    .mvl       (mvl_new),
    .first_len (first_len),
    .first_last(first_last)
  );

  strip_advance #(.N_W(N_W), .LEN_W(LEN_W)) u_adv (
    .base     (base_q),
    .len      (len_q),
    .mvl      (mvl_q),
    .n        (n_q),
    .next_base(next_base),
    .next_last(next_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      n_q     <= '0;
      mvl_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            if (n == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= SEQ_ISSUE;
              n_q     <= n;
              mvl_q   <= mvl_new;
              len_q   <= first_len;
              base_q  <= '0;
              last_q  <= first_last;
            end
          end
        end
        default: begin
          // start is not sampled here: a running sequence owns the block
          if (strip_ready) begin
            if (last_q) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              base_q <= next_base;
              len_q  <= mvl_q;
              last_q <= next_last;
            end
          end
        end
      endcase
    end
  end

  assign strip_valid = (state_q == SEQ_ISSUE);
  assign strip_len   = len_q;
  assign strip_base  = base_q;
  assign strip_last  = last_q;
  assign done        = done_q;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int N_W          = 16,
  parameter int LOG_BASE_MVL = 6,
  parameter int CODE_W       = 2,
  parameter int LEN_W        = LOG_BASE_MVL + (1 << CODE_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [N_W-1:0]    n,
  input logic [CODE_W-1:0] width_code,
  input logic              strip_valid,
  input logic              strip_ready,
  input logic [LEN_W-1:0]  strip_len,
  input logic [N_W-1:0]    strip_base,
  input logic              strip_last,
  input logic              done
);
  logic [LEN_W-1:0] mvl_c;

  // Independent capture of the MVL granted to the running sequence
  always_ff @(posedge clk) begin
    if (rst) mvl_c <= '0;
    else if (start && !strip_valid) mvl_c <= LEN_W'(64) << width_code;
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    strip_valid |-> (strip_len <= mvl_c)); // R5
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strip_valid |-> (strip_len != '0)); // R5
  AST_FIRST_BASE: assert property (@(posedge clk) disable iff (rst)
    (start && !strip_valid && n != '0) |=> (strip_valid && strip_base == '0)); // R2
  AST_FULL_AFTER: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && strip_ready && !strip_last) |=> (strip_valid && strip_len == mvl_c)); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && strip_ready && !strip_last) |=>
      (strip_base == $past(strip_base) + N_W'($past(strip_len)))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && !strip_ready) |=>
      (strip_valid && $stable(strip_len) && $stable(strip_base) && $stable(strip_last))); // R9
  AST_ZERO_N: assert property (@(posedge clk) disable iff (rst)
    (start && !strip_valid && n == '0) |=> (done && !strip_valid)); // R7
  AST_END_DONE: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && strip_ready && strip_last) |=> (done && !strip_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

bind strip_seq strip_seq_chk #(
  .N_W(N_W), .LOG_BASE_MVL(LOG_BASE_MVL), .CODE_W(CODE_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .n(n), .width_code(width_code),
  .strip_valid(strip_valid), .strip_ready(strip_ready), .strip_len(strip_len),
  .strip_base(strip_base), .strip_last(strip_last), .done(done)
);

// File: tb/strip_seq_tb.sv
module strip_seq_tb;
  localparam int N_W = 16;
  localparam int LEN_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [N_W-1:0]   n_in = '0;
  logic [1:0]       wcode = '0;
  logic             ready = 1'b0;
  logic             valid;
  logic [LEN_W-1:0] len;
  logic [N_W-1:0]   base;
  logic             last;
  logic             done;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  strip_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .n(n_in), .width_code(wcode),
    .strip_valid(valid), .strip_ready(ready), .strip_len(len),
    .strip_base(base), .strip_last(last), .done(done)
  );

  typedef struct packed {
    logic [15:0] n;
    logic [1:0]  code;
    logic [15:0] first;
    logic [15:0] count;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'd1,    2'd0, 16'd1,   16'd1},
    '{16'd64,   2'd0, 16'd64,  16'd1},
    '{16'd65,   2'd0, 16'd1,   16'd2},
    '{16'd200,  2'd0, 16'd8,   16'd4},
    '{16'd128,  2'd1, 16'd128, 16'd1},
    '{16'd300,  2'd1, 16'd44,  16'd3},
    '{16'd256,  2'd2, 16'd256, 16'd1},
    '{16'd700,  2'd2, 16'd188, 16'd3},
    '{16'd511,  2'd3, 16'd511, 16'd1},
    '{16'd1024, 2'd3, 16'd512, 16'd2},
    '{16'd1500, 2'd3, 16'd476, 16'd3},
    '{16'd63,   2'd2, 16'd63,  16'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input int nn, input int code, input int exp_first,
                         input int exp_count, input int vi);
    int mvl;
    int b;
    int cnt;
    int l;
    mvl = 64 << code;
    b = 0;
    cnt = 0;
    @(negedge clk);
    start = 1'b1; n_in = N_W'(nn); wcode = 2'(code);
    @(negedge clk);
    start = 1'b0;
    while (b < nn && cnt < 2000) begin
      l = (cnt == 0) ? exp_first : mvl;
      chk(valid == 1'b1, cnt == 0 ? "R2" : "R3", "strip_valid", int'(valid), 1);
      chk(int'(len) == l, cnt == 0 ? "R2" : "R3", "strip_len (R1 MVL)", int'(len), l);
      chk(int'(base) == b, "R4", "strip_base", int'(base), b);
      chk(last == (b + l == nn), "R8", "strip_last", int'(last), int'(b + l == nn));
      if ((cnt + vi) % 3 == 1) begin
        ready = 1'b0;
        @(negedge clk);
        chk(valid && int'(len) == l && int'(base) == b, "R9", "held strip_len", int'(len), l);
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      b += l;
      cnt++;
    end
    chk(cnt == exp_count, "R6", "strip count", cnt, exp_count);
    chk(valid == 1'b0, "R8", "valid after last", int'(valid), 0);
    chk(done == 1'b1, "R8", "done after last", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(valid == 1'b0, "R2", "valid at reset", int'(valid), 0);
    chk(done == 1'b0, "R7", "done at reset", int'(done), 0);

    // table walk
    for (int i = 0; i < NV; i++)
      run_seq(int'(VECS[i].n), int'(VECS[i].code), int'(VECS[i].first),
              int'(VECS[i].count), i);

    // R7: zero trip count
    @(negedge clk);
    start = 1'b1; n_in = '0; wcode = 2'd1;
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b0, "R7", "no strip for n=0", int'(valid), 0);
    chk(done == 1'b1, "R7", "done for n=0", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && valid == 1'b0, "R7", "done one cycle", int'(done), 0);

    // R10: start mid-sequence while stalled (n=130, code 0 -> 2,64,64)
    start = 1'b1; n_in = 16'd130; wcode = 2'd0;
    @(negedge clk);
    start = 1'b1; n_in = 16'd5; wcode = 2'd3;
    chk(int'(len) == 2 && base == '0, "R10", "first strip", int'(len), 2);
    @(negedge clk);
    start = 1'b0;
    chk(int'(len) == 2 && base == '0 && valid, "R10", "ignored start mid-seq", int'(len), 2);
    for (int k = 0; k < 3; k++) begin
      chk(int'(len) == (k == 0 ? 2 : 64), "R10", "strip_len after ignored start",
          int'(len), k == 0 ? 2 : 64);
      chk(int'(base) == (k == 0 ? 0 : 2 + 64 * (k - 1)), "R10", "strip_base after ignored start",
          int'(base), k == 0 ? 0 : 2 + 64 * (k - 1));
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
    end
    chk(valid == 1'b0 && done == 1'b1, "R10", "sequence ended", int'(valid), 0);
    @(negedge clk);

    // R10: start in the same cycle as the final handshake
    start = 1'b1; n_in = 16'd64; wcode = 2'd0;
    @(negedge clk);
    chk(valid && last && int'(len) == 64, "R10", "single strip", int'(len), 64);
    start = 1'b1; n_in = 16'd10; ready = 1'b1;
    @(negedge clk);
    start = 1'b0; ready = 1'b0;
    chk(valid == 1'b0, "R10", "valid after collision", int'(valid), 0);
    chk(done == 1'b1, "R10", "done after collision", int'(done), 1);
    @(negedge clk);
    chk(valid == 1'b0, "R10", "no strip from colliding start", int'(valid), 0);
    chk(done == 1'b0, "R10", "no second done", int'(done), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule